// File: doc/BRIEF.md
# DMA Channel Thread State Controller

This block keeps the run state of a single DMA channel thread. It reacts to one-cycle event pulses from the instruction engine and the debug command path (start, barrier, wait-for-peripheral, end of program, fault and kill), to a data-ready strobe from the peripheral, and to increment and decrement pulses that track outstanding AXI load and store transactions. From these it presents a 3-bit state code and three derived flags: stalled, busy and faulted.

There are eight states. Stopped (code 0) is the idle state. Executing (1) runs the program. At Barrier (4) and Waiting For Peripheral (3) are the two stalls the program asks for. Completing (2), Killing (6) and Faulting Completing (5) are drain states. Each waits for the outstanding transaction count to reach zero. Faulting (7) is a sticky fault park.

The transitions are as follows:
- Start moves the thread from Stopped to Executing.
- From Executing, barrier, wait, end, kill and fault move the thread to the matching state.
- At Barrier returns to Executing once the count is zero.
- Waiting For Peripheral returns to Executing on the data-ready strobe.
- Completing and Killing drain to Stopped.
- Faulting Completing drains to Faulting.
- Faulting leaves only on a kill, which moves it to Stopped.

Software and the instruction decoder use the code and flags to see whether the thread can accept work.

Top module: `dma_thread_fsm`

## Requirements
- R1: After reset the state code is 0 (Stopped) and stalled, busy and faulted are low. In Stopped, every input except ev_start is ignored, and the thread stays in Stopped.
- R2: ev_start in Stopped moves the thread to Executing (code 1) on the next clock. ev_start in any other state is ignored.
- R3: ev_barrier in Executing moves the thread to At Barrier (code 4). It stays there while the outstanding count is nonzero. On the first clock edge at which the registered count is zero it returns to Executing. If the count is zero on entry, it leaves one clock later.
- R4: ev_wait_periph in Executing moves the thread to Waiting For Peripheral (code 3). It stays there until periph_ready is high at a clock edge, then returns to Executing. periph_ready in any other state is ignored.
- R5: ev_end in Executing moves the thread to Completing (code 2). Completing moves to Stopped on the first clock edge at which the registered count is zero.
- R6: ev_kill in Executing, At Barrier or Waiting For Peripheral moves the thread to Killing (code 6). Killing drains to Stopped in the same way as Completing.
- R7: ev_fault in Executing, At Barrier or Waiting For Peripheral moves the thread to Faulting Completing (code 5). Faulting Completing drains to Faulting (code 7).
- R8: Faulting holds with no time limit. Only ev_kill moves it to Stopped. ev_start and all other events are ignored there.
- R9: When several events arrive in the same cycle in Executing, only one is taken. The order, from highest to lowest, is fault, kill, end, barrier, wait-for-peripheral.
- R10: In Completing and Killing, ev_fault and ev_kill do not alter the drain already in progress. In Faulting Completing, ev_kill is ignored.
- R11: The outstanding count is 4 bits wide by default. An increment and a decrement in the same cycle leave it unchanged. A decrement at zero leaves it at zero. An increment at 15 leaves it at 15.
- R12: stalled is high in codes 3, 4, 5 and 7. busy is high in every code except 0 and 7. faulted is high in codes 5 and 7. All three follow the state code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start pulse |
| ev_barrier | input | 1 | Barrier request pulse |
| ev_wait_periph | input | 1 | Wait-for-peripheral request pulse |
| ev_end | input | 1 | End-of-program pulse |
| ev_fault | input | 1 | Fault pulse |
| ev_kill | input | 1 | Kill command pulse from the debug path |
| periph_ready | input | 1 | Peripheral data-ready strobe |
| txn_inc | input | 1 | One load/store transaction issued |
| txn_dec | input | 1 | One load/store transaction completed |
| state_code | output | 3 | Current state code |
| stalled | output | 1 | Thread stalled |
| busy | output | 1 | Thread active |
| faulted | output | 1 | Fault pending or parked |

## Verification
The assertions assume only that every input is sampled once per rising edge and is a legal level at that edge. They do not assume that the pulses are exclusive, or that decrements match earlier increments. The block defines its behaviour for collisions, for a decrement at zero and for an increment at the limit, and the properties check that behaviour.

The random stimulus uses this freedom on purpose. Any subset of events can fire in the same cycle, and unmatched decrements and long runs of increments occur. Directed sequences then drive each drain state with the count both zero and nonzero on entry, so that the next-clock exit case is covered.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    typedef enum logic [2:0] {
        TS_STOPPED  = 3'd0,
        TS_EXEC     = 3'd1,
        TS_COMPLETE = 3'd2,
        TS_WAITPER  = 3'd3,
        TS_BARRIER  = 3'd4,
        TS_FLTDRAIN = 3'd5,
        TS_KILLING  = 3'd6,
        TS_FAULTED  = 3'd7
    } thr_state_t;

    typedef struct packed {
        logic start;
        logic barrier;
        logic waitper;
        logic done;
        logic fault;
        logic kill;
        logic per_ready;
    } thr_evt_t;

endpackage

// File: rtl/dmat_txn_counter.sv
module dmat_txn_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        unique case ({inc, dec})
            2'b10:   cnt_nxt = (cnt == CNT_MAX)  ? cnt : cnt + CNT_ONE;
            2'b01:   cnt_nxt = (cnt == CNT_ZERO) ? cnt : cnt - CNT_ONE;
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= CNT_ZERO;
        else        cnt <= cnt_nxt;
    end

    assign is_zero = (cnt == CNT_ZERO);

    // R11: a decrement at zero leaves the count at zero
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_ZERO && dec && !inc) |=> cnt == CNT_ZERO);

    // R11: an increment at the limit leaves the count at the limit
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && inc && !dec) |=> cnt == CNT_MAX);

    // R11: an increment and a decrement in the same cycle cancel
    assert_pair_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> cnt == $past(cnt));

endmodule

// File: rtl/dmat_next_state.sv
module dmat_next_state
    import dmat_pkg::*;
(
    input  thr_state_t cur,
    input  thr_evt_t   ev,
    input  logic       drained,
    output thr_state_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            TS_STOPPED: begin
                if (ev.start) nxt = TS_EXEC;
            end
            TS_EXEC: begin
                if      (ev.fault)   nxt = TS_FLTDRAIN;
                else if (ev.kill)    nxt = TS_KILLING;
                else if (ev.done)    nxt = TS_COMPLETE;
                else if (ev.barrier) nxt = TS_BARRIER;
                else if (ev.waitper) nxt = TS_WAITPER;
            end
            TS_BARRIER: begin
                if      (ev.fault) nxt = TS_FLTDRAIN;
                else if (ev.kill)  nxt = TS_KILLING;
                else if (drained)  nxt = TS_EXEC;
            end
            TS_WAITPER: begin
                if      (ev.fault)     nxt = TS_FLTDRAIN;
                else if (ev.kill)      nxt = TS_KILLING;
                else if (ev.per_ready) nxt = TS_EXEC;
            end
            TS_COMPLETE: begin
                if (drained) nxt = TS_STOPPED;
            end
            TS_KILLING: begin
                if (drained) nxt = TS_STOPPED;
            end
            TS_FLTDRAIN: begin
                if (drained) nxt = TS_FAULTED;
            end
            TS_FAULTED: begin
                if (ev.kill) nxt = TS_STOPPED;
            end
            default: nxt = TS_STOPPED;
        endcase
    end
endmodule

// File: rtl/dmat_flags.sv
module dmat_flags
    import dmat_pkg::*;
(
    input  thr_state_t st,
    output logic       stalled,
    output logic       busy,
    output logic       faulted
);
    always_comb begin
        stalled = 1'b0;
        busy    = 1'b1;
        faulted = 1'b0;
        unique case (st)
            TS_STOPPED:  busy = 1'b0;
            TS_EXEC:     ;
            TS_COMPLETE: ;
            TS_KILLING:  ;
            TS_WAITPER:  stalled = 1'b1;
            TS_BARRIER:  stalled = 1'b1;
            TS_FLTDRAIN: begin
                stalled = 1'b1;
                faulted = 1'b1;
            end
            TS_FAULTED: begin
                stalled = 1'b1;
                busy    = 1'b0;
                faulted = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_thread_fsm.sv
module dma_thread_fsm
    import dmat_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_barrier,
    input  logic       ev_wait_periph,
    input  logic       ev_end,
    input  logic       ev_fault,
    input  logic       ev_kill,
    input  logic       periph_ready,
    input  logic       txn_inc,
    input  logic       txn_dec,
    output logic [2:0] state_code,
    output logic       stalled,
    output logic       busy,
    output logic       faulted
);
    thr_state_t       state;
    thr_state_t       state_nxt;
    thr_evt_t         evt;
    logic [CNT_W-1:0] txn_cnt;
    logic             txn_zero;

    assign evt = '{start:     ev_start,
                   barrier:   ev_barrier,
                   waitper:   ev_wait_periph,
                   done:      ev_end,
                   fault:     ev_fault,
                   kill:      ev_kill,
                   per_ready: periph_ready};

    dmat_txn_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (txn_inc),
        .dec     (txn_dec),
        .cnt     (txn_cnt),
        .is_zero (txn_zero)
    );

    dmat_next_state u_nxt (
        .cur     (state),
        .ev      (evt),
        .drained (txn_zero),
        .nxt     (state_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_STOPPED;
        else        state <= state_nxt;
    end

    dmat_flags u_flags (
        .st      (state),
        .stalled (stalled),
        .busy    (busy),
        .faulted (faulted)
    );

    assign state_code = state;

    // R1: the thread never leaves Stopped without a start
    assert_no_selfstart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_STOPPED && !ev_start) |=> state == TS_STOPPED);

    // R3: the barrier holds while transactions remain outstanding
    assert_barrier_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_BARRIER && txn_cnt != '0 && !ev_fault && !ev_kill)
        |=> state == TS_BARRIER);

    // R6: a drained kill reaches Stopped one clock later
    assert_kill_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_KILLING && txn_cnt == '0) |=> state == TS_STOPPED);

    // R8: Faulting is sticky without a kill
    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_FAULTED && !ev_kill) |=> state == TS_FAULTED);

    // R9: a fault wins over every other event while executing
    assert_fault_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_EXEC && ev_fault) |=> state == TS_FLTDRAIN);

    // R10: a drain in progress is not redirected by fault or kill
    assert_drain_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_COMPLETE && txn_cnt != '0) |=> state == TS_COMPLETE);

endmodule

// File: tb/test_dma_thread_fsm.sv
module test_dma_thread_fsm;

    localparam int B_START = 0, B_BAR = 1, B_WFP = 2, B_END = 3,
                   B_FAULT = 4, B_KILL = 5, B_PER = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] ev = '0;
    logic inc = 1'b0, dec = 1'b0;
    logic [2:0] state_code;
    logic stalled, busy, faulted;

    int total = 0, bad = 0;
    logic finished = 1'b0;
    logic [2:0] m_st = 3'd0;
    logic [3:0] m_cnt = 4'd0;

    always #5 clk = ~clk;

    dma_thread_fsm i_dma_thread_fsm (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev[B_START]), .ev_barrier(ev[B_BAR]), .ev_wait_periph(ev[B_WFP]),
        .ev_end(ev[B_END]), .ev_fault(ev[B_FAULT]), .ev_kill(ev[B_KILL]),
        .periph_ready(ev[B_PER]), .txn_inc(inc), .txn_dec(dec),
        .state_code(state_code), .stalled(stalled), .busy(busy), .faulted(faulted)
    );

    // Reference rules taken from the requirements
    function automatic logic [2:0] m_next(logic [2:0] s, logic [3:0] c, logic [6:0] e);
        logic z = (c == 4'd0);
        case (s)
            3'd0: return e[B_START] ? 3'd1 : 3'd0;
            3'd1: begin
                if (e[B_FAULT]) return 3'd5;
                if (e[B_KILL])  return 3'd6;
                if (e[B_END])   return 3'd2;
                if (e[B_BAR])   return 3'd4;
                if (e[B_WFP])   return 3'd3;
                return 3'd1;
            end
            3'd4: begin
                if (e[B_FAULT]) return 3'd5;
                if (e[B_KILL])  return 3'd6;
                return z ? 3'd1 : 3'd4;
            end
            3'd3: begin
                if (e[B_FAULT]) return 3'd5;
                if (e[B_KILL])  return 3'd6;
                return e[B_PER] ? 3'd1 : 3'd3;
            end
            3'd2, 3'd6: return z ? 3'd0 : s;
            3'd5: return z ? 3'd7 : 3'd5;
            default: return e[B_KILL] ? 3'd0 : 3'd7;
        endcase
    endfunction

    function automatic logic [3:0] m_cnt_next(logic [3:0] c, logic i, logic d);
        if (i && !d) return (c == 4'd15) ? c : c + 4'd1;
        if (d && !i) return (c == 4'd0) ? c : c - 4'd1;
        return c;
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R3";
            3'd5: return "R7";
            3'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "state_code", state_code, m_st);
        check("R12", "stalled", stalled,
              (m_st == 3'd3 || m_st == 3'd4 || m_st == 3'd5 || m_st == 3'd7));
        check("R12", "busy", busy, (m_st != 3'd0 && m_st != 3'd7));
        check("R12", "faulted", faulted, (m_st == 3'd5 || m_st == 3'd7));
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare.
    task automatic step(string tag, logic [6:0] e, logic i, logic d);
        ev = e; inc = i; dec = d;
        @(posedge clk);
        m_st  = m_next(m_st, m_cnt, e);
        m_cnt = m_cnt_next(m_cnt, i, d);
        #1;
        check((tag == "") ? tag_of(m_st) : tag, "state_code", state_code, m_st);
        check("R12", "stalled", stalled,
              (m_st == 3'd3 || m_st == 3'd4 || m_st == 3'd5 || m_st == 3'd7));
        check("R12", "busy", busy, (m_st != 3'd0 && m_st != 3'd7));
        check("R12", "faulted", faulted, (m_st == 3'd5 || m_st == 3'd7));
        @(negedge clk);
        ev = '0; inc = 1'b0; dec = 1'b0;
    endtask

    function automatic logic [6:0] E(int b);
        return 7'(1 << b);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R1: events other than start are ignored in Stopped
        step("R1", E(B_BAR) | E(B_END) | E(B_KILL) | E(B_FAULT) | E(B_PER), 1'b0, 1'b0);
        step("R1", E(B_WFP), 1'b0, 1'b0);
        // R2: start, then start again is ignored
        step("R2", E(B_START), 1'b0, 1'b0);
        step("R2", E(B_START), 1'b0, 1'b0);
        // R3: barrier with three outstanding
        step("R3", '0, 1'b1, 1'b0);
        step("R3", '0, 1'b1, 1'b0);
        step("R3", '0, 1'b1, 1'b0);
        step("R3", E(B_BAR), 1'b0, 1'b0);
        step("R3", '0, 1'b0, 1'b1);
        step("R3", '0, 1'b0, 1'b1);
        step("R3", '0, 1'b0, 1'b1);
        step("R3", '0, 1'b0, 1'b0);
        // R3: barrier with zero outstanding leaves next clock
        step("R3", E(B_BAR), 1'b0, 1'b0);
        step("R3", '0, 1'b0, 1'b0);
        // R4: wait for peripheral
        step("R4", E(B_WFP), 1'b0, 1'b0);
        step("R4", '0, 1'b0, 1'b0);
        step("R4", E(B_PER), 1'b0, 1'b0);
        step("R4", E(B_PER), 1'b0, 1'b0);
        // R5 and R10: end with one outstanding, fault and kill ignored
        step("R5", E(B_END), 1'b1, 1'b0);
        step("R10", E(B_FAULT), 1'b0, 1'b0);
        step("R10", E(B_KILL), 1'b0, 1'b0);
        step("R5", '0, 1'b0, 1'b1);
        step("R5", '0, 1'b0, 1'b0);
        // R6 and R10: kill from a barrier, fault during the drain ignored
        step("R2", E(B_START), 1'b1, 1'b0);
        step("R6", E(B_BAR), 1'b0, 1'b0);
        step("R6", E(B_KILL), 1'b0, 1'b0);
        step("R10", E(B_FAULT), 1'b0, 1'b0);
        step("R6", '0, 1'b0, 1'b1);
        step("R6", '0, 1'b0, 1'b0);
        // R7, R8 and R10: fault from waiting with two outstanding
        step("R2", E(B_START), 1'b1, 1'b0);
        step("R7", E(B_WFP), 1'b1, 1'b0);
        step("R7", E(B_FAULT), 1'b0, 1'b0);
        step("R10", E(B_KILL), 1'b0, 1'b1);
        step("R7", '0, 1'b0, 1'b1);
        step("R7", '0, 1'b0, 1'b0);
        step("R8", E(B_START), 1'b0, 1'b0);
        step("R8", E(B_END) | E(B_PER), 1'b0, 1'b0);
        step("R8", E(B_KILL), 1'b0, 1'b0);
        // R9: collisions while executing
        step("R2", E(B_START), 1'b0, 1'b0);
        step("R9", 7'h3E, 1'b0, 1'b0);
        step("R9", '0, 1'b0, 1'b0);
        step("R9", E(B_KILL), 1'b0, 1'b0);
        step("R2", E(B_START), 1'b0, 1'b0);
        step("R9", E(B_KILL) | E(B_END) | E(B_BAR), 1'b0, 1'b0);
        step("R9", '0, 1'b0, 1'b0);
        step("R2", E(B_START), 1'b0, 1'b0);
        step("R9", E(B_END) | E(B_BAR) | E(B_WFP), 1'b0, 1'b0);
        step("R9", '0, 1'b0, 1'b0);
        step("R2", E(B_START), 1'b0, 1'b0);
        step("R9", E(B_BAR) | E(B_WFP), 1'b0, 1'b0);
        step("R9", '0, 1'b0, 1'b0);
        // R11: unmatched decrements, paired pulses, saturation
        step("R11", '0, 1'b0, 1'b1);
        step("R11", '0, 1'b0, 1'b1);
        step("R11", '0, 1'b1, 1'b0);
        step("R11", '0, 1'b1, 1'b1);
        step("R11", E(B_BAR), 1'b0, 1'b0);
        step("R11", '0, 1'b0, 1'b0);
        step("R11", '0, 1'b0, 1'b1);
        step("R11", '0, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) step("R11", '0, 1'b1, 1'b0);
        step("R11", E(B_BAR), 1'b0, 1'b0);
        for (int k = 0; k < 15; k++) step("R11", '0, 1'b0, 1'b1);
        step("R11", '0, 1'b0, 1'b0);

        // Random phase with a fixed seed
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 4000; k++) begin
            logic [6:0] e;
            e[B_START] = ($urandom % 6) == 0;
            e[B_BAR]   = ($urandom % 12) == 0;
            e[B_WFP]   = ($urandom % 12) == 0;
            e[B_END]   = ($urandom % 20) == 0;
            e[B_FAULT] = ($urandom % 30) == 0;
            e[B_KILL]  = ($urandom % 16) == 0;
            e[B_PER]   = ($urandom % 4) == 0;
            step("", e, ($urandom % 3) == 0, ($urandom % 3) == 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule